// File: doc/BRIEF.md
# Second-Chance Eviction Victim Selector

This block picks a physical frame to give up when memory runs short. It keeps one small record per frame holding four flags: present, accessed, dirty and pinned. A clock hand points at one record. A scan request walks the hand forward, one record per clock cycle. A present, unpinned frame whose accessed flag is set gets that flag cleared and is passed over, so it gets a second chance. The first present, unpinned frame found with its accessed flag clear becomes the victim. The scan then ends and the hand is left on the record after the victim.

The result reports the victim index and its dirty flag. A dirty victim must be written to backing store before its frame is reused; a clean one needs no write-back. If no frame is eligible, the scan ends with a no-victim indication after two full revolutions. Two write ports keep the records current:
- A load port writes all four flags of one record.
- A use port marks a frame as touched: it always sets accessed, and it also sets dirty on a write.

Write-back, freeing the frame and translation invalidation belong to the caller.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every record has all four flags clear, the hand is at index 0, and scan_busy, scan_done and no_victim are low.
- R2: A scan_req seen while idle starts a scan at the current hand, one record per cycle. The scan_done pulse lasts exactly one cycle and arrives s+1 cycles after the accepting edge, where s is the number of records examined before the deciding one.
- R3: A present, unpinned record with accessed=1 is passed over and its accessed flag is cleared.
- R4: The first present, unpinned record reached with accessed=0 becomes the victim, and its index is given on victim_idx.
- R5: Records that are not present or that are pinned are skipped without change and are never chosen.
- R6: victim_dirty equals the dirty flag of the victim record at the moment it was chosen.
- R7: After a victim is chosen, the hand points to the index after the victim, wrapping from N_FRAMES-1 to 0.
- R8: If every eligible record starts with accessed=1, the first revolution clears them all and the scan picks the first one it visited. No scan lasts more than 2*N_FRAMES cycles.
- R9: With no present, unpinned record, the scan ends after 2*N_FRAMES cycles with no_victim=1, and the hand is back where the scan started.
- R10: When a use update hits the record being cleared by the scan in the same cycle, the accessed flag ends up set.
- R11: A scan_req raised while a scan is in progress is ignored and does not change the running scan.
- R12: The load port writes present, pinned, accessed and dirty of one record. The use port sets accessed, and also sets dirty when use_write=1, but never clears a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one record with the ld_* flags |
| ld_idx | input | IDX_W | Record written by the load port |
| ld_present | input | 1 | Present flag to load |
| ld_pinned | input | 1 | Pinned flag to load |
| ld_acc | input | 1 | Accessed flag to load |
| ld_dirty | input | 1 | Dirty flag to load |
| use_en | input | 1 | Mark a record as used |
| use_idx | input | IDX_W | Record marked by the use port |
| use_write | input | 1 | The use was a write; also set dirty |
| scan_req | input | 1 | Start a victim search |
| scan_busy | output | 1 | A search is running |
| scan_done | output | 1 | One-cycle end-of-search pulse |
| no_victim | output | 1 | The last search found no eligible frame |
| victim_idx | output | IDX_W | Index of the chosen frame |
| victim_dirty | output | 1 | The chosen frame needs write-back |

## Verification
The scan clearing a record's accessed flag and the use port setting that same flag can happen in the same cycle. The bench sets this up with two eligible records, both with accessed=1. It fires a read-use on the record under the hand in exactly the first scan cycle. Had the clear won, the hand's record would be chosen on the second pass after 9 cycles. Because the update must win, the neighbour is chosen after 10 cycles, and the bench checks that result. A checker also confirms that any such use leaves the flag set.

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int N_FRAMES = 8,
  parameter int IDX_W = $clog2(N_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic             ld_present,
  input  logic             ld_pinned,
  input  logic             ld_acc,
  input  logic             ld_dirty,
  input  logic             use_en,
  input  logic [IDX_W-1:0] use_idx,
  input  logic             use_write,
  input  logic             scan_req,
  output logic             scan_busy,
  output logic             scan_done,
  output logic             no_victim,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_dirty
);
  localparam int STW = IDX_W + 1;

  logic [N_FRAMES-1:0] pres_q, pin_q, acc_q, dirty_q;
  logic [IDX_W-1:0]    hand_q, hand_nxt;
  logic [STW-1:0]      step_q;
  logic                busy_q, done_q, nv_q, vdirty_q;
  logic [IDX_W-1:0]    vidx_q;

  wire elig = pres_q[hand_q] & ~pin_q[hand_q];
  wire pick = busy_q & elig & ~acc_q[hand_q];
  wire pass = busy_q & elig & acc_q[hand_q];
  wire last = step_q == STW'(2 * N_FRAMES - 1);

  assign hand_nxt = (hand_q == IDX_W'(N_FRAMES - 1)) ? '0 : hand_q + 1'b1;

  for (genvar i = 0; i < N_FRAMES; i++) begin : g_rec
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pres_q[i]  <= 1'b0;
        pin_q[i]   <= 1'b0;
        acc_q[i]   <= 1'b0;
        dirty_q[i] <= 1'b0;
      end else if (ld_en && ld_idx == IDX_W'(i)) begin
        pres_q[i]  <= ld_present;
        pin_q[i]   <= ld_pinned;
        acc_q[i]   <= ld_acc;
        dirty_q[i] <= ld_dirty;
      end else begin
        if (pass && hand_q == IDX_W'(i))
          acc_q[i] <= 1'b0;
        if (use_en && use_idx == IDX_W'(i)) begin
          acc_q[i] <= 1'b1;
          if (use_write)
            dirty_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hand_q   <= '0;
      step_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      nv_q     <= 1'b0;
      vidx_q   <= '0;
      vdirty_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (scan_req) begin
          busy_q <= 1'b1;
          step_q <= '0;
        end
      end else begin
        hand_q <= hand_nxt;
        step_q <= step_q + 1'b1;
        if (pick) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          nv_q     <= 1'b0;
          vidx_q   <= hand_q;
          vdirty_q <= dirty_q[hand_q];
        end else if (last) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          nv_q     <= 1'b1;
          vdirty_q <= 1'b0;
        end
      end
    end
  end

  assign scan_busy    = busy_q;
  assign scan_done    = done_q;
  assign no_victim    = nv_q;
  assign victim_idx   = vidx_q;
  assign victim_dirty = vdirty_q;
endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int N_FRAMES = 8,
  parameter int IDX_W = $clog2(N_FRAMES)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ld_en,
  input logic [IDX_W-1:0]    ld_idx,
  input logic                use_en,
  input logic [IDX_W-1:0]    use_idx,
  input logic                scan_req,
  input logic                busy,
  input logic                done,
  input logic                nv,
  input logic [IDX_W-1:0]    vidx,
  input logic                vdirty,
  input logic [IDX_W-1:0]    hand,
  input logic [N_FRAMES-1:0] pres,
  input logic [N_FRAMES-1:0] pin,
  input logic [N_FRAMES-1:0] acc,
  input logic [N_FRAMES-1:0] dirty
);
  logic [N_FRAMES-1:0] pres_d, pin_d, acc_d, dirty_d;
  logic [IDX_W-1:0]    hand_d, uidx_d;
  logic [IDX_W+1:0]    busy_len;
  logic                use_d, ld_in_scan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_d <= '0; pin_d <= '0; acc_d <= '0; dirty_d <= '0;
      hand_d <= '0; uidx_d <= '0; busy_len <= '0;
      use_d <= 1'b0; ld_in_scan <= 1'b0;
    end else begin
      pres_d <= pres; pin_d <= pin; acc_d <= acc; dirty_d <= dirty;
      hand_d <= hand;
      uidx_d <= use_idx;
      use_d  <= use_en && !(ld_en && ld_idx == use_idx);
      busy_len <= busy ? busy_len + 1'b1 : '0;
      if (!busy && scan_req) ld_in_scan <= ld_en;
      else if (busy && ld_en) ld_in_scan <= 1'b1;
    end
  end

  wire [IDX_W-1:0] after_victim = (vidx == IDX_W'(N_FRAMES - 1)) ? '0 : vidx + 1'b1;

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_victim_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !nv |-> vidx == hand_d && !acc_d[hand_d]);
  assert_victim_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !nv |-> pres_d[hand_d] && !pin_d[hand_d]);
  assert_victim_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !nv |-> vdirty == dirty_d[hand_d]);
  assert_hand_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !nv |-> hand == after_victim);
  assert_scan_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_len < (IDX_W+2)'(2 * N_FRAMES));
  assert_no_victim_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && nv && !ld_in_scan |-> (pres & ~pin) == '0);
  assert_use_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    use_d |-> acc[uidx_d]);
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.N_FRAMES(N_FRAMES), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
  .use_en(use_en), .use_idx(use_idx), .scan_req(scan_req),
  .busy(scan_busy), .done(scan_done), .nv(no_victim), .vidx(victim_idx),
  .vdirty(victim_dirty), .hand(hand_q), .pres(pres_q), .pin(pin_q),
  .acc(acc_q), .dirty(dirty_q)
);

// File: tb/clock_victim_sel_tb.sv
module clock_victim_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_en = 0, ld_present = 0, ld_pinned = 0, ld_acc = 0, ld_dirty = 0;
  logic [IW-1:0] ld_idx = '0, use_idx = '0;
  logic use_en = 0, use_write = 0, scan_req = 0;
  logic scan_busy, scan_done, no_victim, victim_dirty;
  logic [IW-1:0] victim_idx;

  int n_checks = 0, n_errors = 0;
  bit m_pres[N], m_pin[N], m_acc[N], m_dirty[N];
  int m_hand = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clock_victim_sel #(.N_FRAMES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_present(ld_present), .ld_pinned(ld_pinned), .ld_acc(ld_acc), .ld_dirty(ld_dirty),
    .use_en(use_en), .use_idx(use_idx), .use_write(use_write), .scan_req(scan_req),
    .scan_busy(scan_busy), .scan_done(scan_done), .no_victim(no_victim),
    .victim_idx(victim_idx), .victim_dirty(victim_dirty)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
  end

  task automatic do_load(int i, bit p, bit pn, bit a, bit d);
    @(negedge clk);
    ld_en = 1; ld_idx = IW'(i); ld_present = p; ld_pinned = pn; ld_acc = a; ld_dirty = d;
    @(negedge clk);
    ld_en = 0;
    m_pres[i] = p; m_pin[i] = pn; m_acc[i] = a; m_dirty[i] = d;
  endtask

  task automatic do_use(int i, bit w);
    @(negedge clk);
    use_en = 1; use_idx = IW'(i); use_write = w;
    @(negedge clk);
    use_en = 0; use_write = 0;
    m_acc[i] = 1; if (w) m_dirty[i] = 1;
  endtask

  task automatic model_scan(output bit nv, output int vic, output bit vd, output int cyc);
    int h = m_hand;
    nv = 1; vic = 0; vd = 0; cyc = 2 * N;
    for (int s = 0; s < 2 * N; s++) begin
      if (m_pres[h] && !m_pin[h]) begin
        if (m_acc[h]) m_acc[h] = 0;
        else begin
          nv = 0; vic = h; vd = m_dirty[h]; cyc = s + 1;
          m_hand = (h + 1) % N;
          return;
        end
      end
      h = (h + 1) % N;
    end
    m_hand = h;
  endtask

  // poke: raise scan_req for one cycle mid-scan; collide: read-use on the hand in the first scan cycle
  task automatic run_scan(string tag, bit poke, bit collide,
                          output bit nv, output int vic, output bit vd, output int cyc);
    int h0 = m_hand;
    @(negedge clk);
    scan_req = 1;
    @(posedge clk);
    @(negedge clk);
    scan_req = 0;
    if (collide) begin use_en = 1; use_idx = IW'(h0); use_write = 0; end
    cyc = 0;
    while (1) begin
      @(posedge clk);
      @(negedge clk);
      use_en = 0;
      cyc++;
      if (poke && cyc == 1) scan_req = 1;
      else if (poke && cyc == 2) scan_req = 0;
      if (scan_done) break;
      if (cyc > 4 * N) break;
    end
    scan_req = 0;
    nv = no_victim; vic = int'(victim_idx); vd = victim_dirty;
  endtask

  task automatic scan_and_check(string tag, bit poke);
    bit env, anv, evd, avd;
    int evic, ecyc, avic, acyc;
    model_scan(env, evic, evd, ecyc);
    run_scan(tag, poke, 0, anv, avic, avd, acyc);
    check(acyc == ecyc, {tag, " R2 scan length"}, acyc, ecyc);
    check(anv == env, {tag, " R9 no_victim"}, anv, env);
    if (!env) begin
      check(avic == evic, {tag, " R4 victim index"}, avic, evic);
      check(avd == evd, {tag, " R6 victim dirty"}, avd, evd);
    end
    if (poke) begin
      @(negedge clk);
      check(scan_busy == 0, {tag, " R11 request during scan ignored"}, scan_busy, 0);
    end
  endtask

  initial begin
    int seed;
    bit cnv, cvd;
    int cvic, ccyc, h;
    seed = $urandom(1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check(scan_busy == 0 && scan_done == 0 && no_victim == 0, "R1 reset outputs", scan_busy, 0);
    scan_and_check("R1 empty table", 0);
    // R9: the hand returns to its start, so the next victim at index 0 takes one cycle
    do_load(0, 1, 0, 0, 1);
    scan_and_check("R9 hand unchanged / R6 dirty victim", 0);
    // R3 R5 R7: from hand 1, pinned, absent, accessed, then clean victim at 4
    do_load(1, 1, 1, 0, 0);
    do_load(2, 0, 0, 0, 0);
    do_load(3, 1, 0, 1, 0);
    do_load(4, 1, 0, 0, 0);
    scan_and_check("R3 R5 R7 skip and clear", 0);
    // R8: every record present with accessed=1
    for (int i = 0; i < N; i++) do_load(i, 1, 0, 1, i[0]);
    scan_and_check("R8 full second chance", 0);
    // R7: the next scan continues after the last victim
    scan_and_check("R7 continue after victim", 0);
    // R11: extra request during a long scan
    for (int i = 0; i < N; i++) do_load(i, 1, 0, 1, 0);
    scan_and_check("R11 poke", 1);
    // R12: use port sets dirty on a write
    for (int i = 0; i < N; i++) do_load(i, 0, 0, 0, 0);
    do_load(6, 1, 0, 0, 0);
    do_use(6, 1);
    scan_and_check("R12 use write sets dirty", 0);
    // R10: use and clear on the same record in the same cycle
    for (int i = 0; i < N; i++) do_load(i, 0, 0, 0, 0);
    h = m_hand;
    do_load(h, 1, 0, 1, 0);
    do_load((h + 1) % N, 1, 0, 1, 0);
    run_scan("R10", 0, 1, cnv, cvic, cvd, ccyc);
    check(cnv == 0, "R10 victim found", cnv, 0);
    check(cvic == (h + 1) % N, "R10 update wins over clear", cvic, (h + 1) % N);
    check(ccyc == 10, "R10 scan length", ccyc, 10);
    m_acc[h] = 0; m_acc[(h + 1) % N] = 0; m_hand = (h + 2) % N;
    // random mix
    for (int t = 0; t < 40; t++) begin
      int nl = $urandom_range(1, 4);
      for (int k = 0; k < nl; k++)
        do_load($urandom_range(0, N - 1), ($urandom_range(0, 3) != 0),
                ($urandom_range(0, 7) == 0), $urandom_range(0, 1), $urandom_range(0, 1));
      if ($urandom_range(0, 1)) do_use($urandom_range(0, N - 1), $urandom_range(0, 1));
      scan_and_check("random R3 R4 R5", 0);
    end
    report();
  end
endmodule